// File: doc/BRIEF.md
# ADC Scan Loop Rate Scheduler

This block decides, slot by slot, what a battery-monitor ADC converts next. Work is grouped into loops. A full loop converts every cell voltage (`N_VOLT` slots) and then the temperature inputs (`N_TEMP` slots). After each full loop the scheduler can add a number of current-only loops of one slot each. Adding them lowers the voltage measurement rate to one half, one quarter or one eighth of full speed. Two 2-bit rate codes are provided. One applies while cell balancing runs and the other applies while it does not. This lets the voltage rate be reduced during balancing, which raises the balancing duty cycle.

Each conversion lasts a fixed number of timebase ticks. That count is set by a fast-mode input: 6 ticks normally and 3 in fast mode, with the defaults. A one-cycle strobe marks the start of every conversion, and the slot type is presented beside it. Because cell balancing must not run while a cell voltage is being converted, a pause output stays high for the whole of every voltage slot. The ADC itself and its datapath are not part of this block.

The FSM states match the slot types: `SLOT_VOLT`, `SLOT_TEMP` and `SLOT_CURR`. The transitions are as follows:
- **VOLT→VOLT**: moves on to the next cell.
- **VOLT→TEMP**: taken after the last voltage slot.
- **TEMP→TEMP**: moves on to the next temperature input.
- **TEMP→CURR**: taken when current loops are owed.
- **TEMP→VOLT**: taken when no current loops are owed.
- **CURR→CURR**: taken while current loops remain.
- **CURR→VOLT**: taken after the last current loop.

Top module: `adc_scan_sched`

## Requirements
- R1: While reset is held, `conv_start` is 0 and `slot_type` is 0. In the first cycle after the first clock edge following reset release, `conv_start` is 1 with `slot_type` 0 (voltage).
- R2: `slot_type` uses code 0 for voltage, 1 for temperature and 2 for current. Code 3 never appears. A full loop is `N_VOLT` voltage slots followed by `N_TEMP` temperature slots. Each slot begins with a strobe, and `slot_type` changes only in a strobe cycle.
- R3: After the temperature slots of a loop, a rate code n (0..3) inserts exactly 2^n−1 current slots before the next voltage slot.
- R4: While `bal_active` is 1, the code is taken from `bal_speed`. Otherwise it is taken from `idle_speed`.
- R5: `bal_active`, `bal_speed` and `idle_speed` are sampled only in the strobe cycle of the first voltage slot of a loop. Changes at any other time do not alter the current slots of that loop.
- R6: A conversion ends on its `TICKS_SLOW` (6) counted tick, or on its `TICKS_FAST` (3) counted tick if `fast_mode` was 1 in its strobe cycle. The next strobe follows in the cycle after that tick.
- R7: `conv_start` is never high for two consecutive cycles.
- R8: `bal_pause` is 1 exactly when `slot_type` is 0.
- R9: A tick that arrives in a strobe cycle is not counted toward that conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase pulse, one per tick period |
| fast_mode | input | 1 | Selects the short conversion length |
| bal_active | input | 1 | Cell balancing is running |
| bal_speed | input | 2 | Rate code used while balancing |
| idle_speed | input | 2 | Rate code used while not balancing |
| conv_start | output | 1 | One-cycle strobe at the start of each conversion |
| slot_type | output | 2 | 0 voltage, 1 temperature, 2 current |
| bal_pause | output | 1 | Holds balancing off during voltage slots |

## Verification
A wrong state or slot count shows at the next strobe: the `slot_type` presented there is wrong, and `bal_pause` is raised or dropped at the wrong time. A stale or miscounted current-loop counter shows as a run of current strobes of the wrong length, which appears at the start of the following full loop. Errors in the conversion-length latch or in the tick counter move the next strobe by at least one cycle, so the per-cycle comparison against the behavioural model detects them within one conversion.

// File: rtl/adc_scan_sched_pkg.sv
package adc_scan_sched_pkg;
    typedef enum logic [1:0] {
        SLOT_VOLT = 2'd0,
        SLOT_TEMP = 2'd1,
        SLOT_CURR = 2'd2
    } slot_t;
endpackage

// File: rtl/loop_rate_sel.sv
module loop_rate_sel (
    input  logic       bal_active,
    input  logic [1:0] bal_speed,
    input  logic [1:0] idle_speed,
    output logic [2:0] extra_loops
);
    logic [1:0] code;

    always_comb begin
        code = bal_active ? bal_speed : idle_speed;
        unique case (code)
            2'd0: extra_loops = 3'd0;
            2'd1: extra_loops = 3'd1;
            2'd2: extra_loops = 3'd3;
            2'd3: extra_loops = 3'd7;
        endcase
    end
endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
    parameter int TICKS_SLOW = 6,
    parameter int TICKS_FAST = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic fast,
    input  logic tick,
    output logic done
);
    localparam int MAXT = (TICKS_SLOW > TICKS_FAST) ? TICKS_SLOW : TICKS_FAST;
    localparam int TW   = (MAXT > 1) ? $clog2(MAXT + 1) : 1;

    logic [TW-1:0] cnt_q;
    logic [TW-1:0] len_q;

    assign done = !start && tick && (cnt_q == len_q - TW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            len_q <= TW'(TICKS_SLOW);
        end else if (start) begin
            cnt_q <= '0;
            len_q <= fast ? TW'(TICKS_FAST) : TW'(TICKS_SLOW);
        end else if (tick) begin
            cnt_q <= done ? '0 : cnt_q + TW'(1);
        end
    end
endmodule

// File: rtl/adc_scan_sched.sv
module adc_scan_sched
    import adc_scan_sched_pkg::*;
#(
    parameter int N_VOLT     = 2,
    parameter int N_TEMP     = 1,
    parameter int TICKS_SLOW = 6,
    parameter int TICKS_FAST = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       fast_mode,
    input  logic       bal_active,
    input  logic [1:0] bal_speed,
    input  logic [1:0] idle_speed,
    output logic       conv_start,
    output logic [1:0] slot_type,
    output logic       bal_pause
);
    localparam int MAXS  = (N_VOLT > N_TEMP) ? N_VOLT : N_TEMP;
    localparam int CNT_W = (MAXS > 1) ? $clog2(MAXS) : 1;

    slot_t            state_q, state_nx;
    logic [CNT_W-1:0] idx_q, idx_nx;
    logic [2:0]       rem_q, extra_loops;
    logic             first_q, start_q, conv_done, loop_head;

    loop_rate_sel u_rate (
        .bal_active (bal_active),
        .bal_speed  (bal_speed),
        .idle_speed (idle_speed),
        .extra_loops(extra_loops)
    );

    conv_timer #(
        .TICKS_SLOW(TICKS_SLOW),
        .TICKS_FAST(TICKS_FAST)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start_q | first_q),
        .fast (fast_mode),
        .tick (tick),
        .done (conv_done)
    );

    assign loop_head = start_q && (state_q == SLOT_VOLT) && (idx_q == '0);

    // Next slot, evaluated when a conversion finishes
    always_comb begin
        state_nx = state_q;
        idx_nx   = idx_q;
        unique case (state_q)
            SLOT_VOLT: begin
                if (idx_q == CNT_W'(N_VOLT - 1)) begin
                    state_nx = SLOT_TEMP;
                    idx_nx   = '0;
                end else begin
                    idx_nx = idx_q + CNT_W'(1);
                end
            end
            SLOT_TEMP: begin
                if (idx_q == CNT_W'(N_TEMP - 1)) begin
                    state_nx = (rem_q == 3'd0) ? SLOT_VOLT : SLOT_CURR;
                    idx_nx   = '0;
                end else begin
                    idx_nx = idx_q + CNT_W'(1);
                end
            end
            SLOT_CURR: begin
                if (rem_q == 3'd1) state_nx = SLOT_VOLT;
            end
            default: state_nx = SLOT_VOLT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_VOLT;
            idx_q   <= '0;
            rem_q   <= 3'd0;
            first_q <= 1'b1;
            start_q <= 1'b0;
        end else begin
            first_q <= 1'b0;
            start_q <= first_q | conv_done;
            if (loop_head) rem_q <= extra_loops;
            if (conv_done) begin
                state_q <= state_nx;
                idx_q   <= idx_nx;
                if (state_q == SLOT_CURR) rem_q <= rem_q - 3'd1;
            end
        end
    end

    // Outputs
    always_comb begin
        conv_start = start_q;
        slot_type  = state_q;
        bal_pause  = (state_q == SLOT_VOLT);
    end
endmodule

// File: rtl/adc_scan_sched_chk.sv
module adc_scan_sched_chk #(
    parameter int TICKS_FAST = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       conv_start,
    input logic [1:0] slot_type,
    input logic       bal_pause
);
    logic [7:0] tcnt;
    logic       seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt <= 8'd0;
            seen <= 1'b0;
        end else if (conv_start) begin
            tcnt <= 8'd0;
            seen <= 1'b1;
        end else if (tick && tcnt != 8'hFF) begin
            tcnt <= tcnt + 8'd1;
        end
    end

    assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    assert_legal_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_type != 2'd3);

    assert_change_at_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_type != $past(slot_type)) |-> conv_start);

    assert_curr_after_temp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && slot_type == 2'd2 && $past(slot_type) != 2'd2)
            |-> ($past(slot_type) == 2'd1));

    assert_min_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && seen) |-> (tcnt >= 8'(TICKS_FAST)));

    assert_pause_only_volt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && slot_type != 2'd0) |-> !bal_pause);
endmodule

bind adc_scan_sched adc_scan_sched_chk #(.TICKS_FAST(TICKS_FAST)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .conv_start(conv_start),
    .slot_type (slot_type),
    .bal_pause (bal_pause)
);

// File: tb/adc_scan_sched_test.sv
module adc_scan_sched_test;
    localparam int NV = 2, NT = 1, TS = 6, TF = 3;

    logic clk = 0, rst_n = 0, tick = 0, fast_mode = 0, bal_active = 0;
    logic [1:0] bal_speed = 0, idle_speed = 0;
    logic conv_start, bal_pause;
    logic [1:0] slot_type;

    integer n_tests = 0, n_fail = 0, cyc = 0;
    integer tick_mode = 0;
    logic rnd_cfg = 0;
    logic [15:0] lfsr = 16'hACE1;

    adc_scan_sched #(.N_VOLT(NV), .N_TEMP(NT), .TICKS_SLOW(TS), .TICKS_FAST(TF)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .fast_mode(fast_mode),
        .bal_active(bal_active), .bal_speed(bal_speed), .idle_speed(idle_speed),
        .conv_start(conv_start), .slot_type(slot_type), .bal_pause(bal_pause));

    always #10 clk = ~clk;

    // Stimulus updated away from the active edge
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (tick_mode)
            0: tick <= 1'b1;
            1: tick <= (cyc % 3 == 0);
            default: tick <= lfsr[3];
        endcase
        if (rnd_cfg && lfsr[4:0] == 5'd7) begin
            fast_mode  <= lfsr[6];
            bal_active <= lfsr[7];
            bal_speed  <= lfsr[9:8];
            idle_speed <= lfsr[11:10];
        end
    end

    // Behavioural reference model
    integer q[$];
    integer m_cur, m_cnt, m_len;
    logic m_first, m_start, m_head, launch;
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            q.delete();
            m_first = 1; m_start = 0; m_head = 0; m_cur = 0; m_cnt = 0; m_len = TS;
        end else begin
            launch = 0;
            if (m_first) begin
                m_first = 0; launch = 1;
            end else if (m_start) begin
                m_start = 0; m_cnt = 0;
                m_len = fast_mode ? TF : TS;
                if (m_head) begin
                    m_head = 0;
                    for (int i = 1; i < NV; i++) q.push_back(0);
                    for (int i = 0; i < NT; i++) q.push_back(1);
                    for (int i = 0; i < (1 << (bal_active ? bal_speed : idle_speed)) - 1; i++)
                        q.push_back(2);
                end
            end else if (tick) begin
                if (m_cnt == m_len - 1) launch = 1;
                else m_cnt = m_cnt + 1;
            end
            if (launch) begin
                m_start = 1;
                if (q.size() == 0) begin m_cur = 0; m_head = 1; end
                else m_cur = q.pop_front();
            end
        end
    end

    task automatic check(input string req, input integer got, input integer exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %0d expected %0d (cycle %0d)", req, got, exp, cyc);
        end
    endtask

    // Observers and per-cycle comparison
    integer last_strobe = 0, gap = 0, curr_run = 0, last_run = -1, prev_type = 0;
    logic cmp_on = 0;
    always @(negedge clk) begin
        if (cmp_on) begin
            check("R7/R6/R9 conv_start", conv_start, m_start);
            check("R2/R3/R4/R5 slot_type", slot_type, m_cur);
            check("R8 bal_pause", bal_pause, m_cur == 0);
        end
        if (rst_n && conv_start) begin
            gap = cyc - last_strobe;
            last_strobe = cyc;
            if (slot_type == 2) curr_run++;
            else if (slot_type == 1) curr_run = 0;
            else if (prev_type != 0) last_run = curr_run;
            prev_type = slot_type;
        end
    end

    logic finished = 0;
    always @(posedge clk) begin
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic run(input integer n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle_speed = 2'd3;
        run(3);
        // R1: reset state
        check("R1 conv_start in reset", conv_start, 0);
        check("R1 slot_type in reset", slot_type, 0);
        rst_n = 1;
        @(negedge clk);
        check("R1 first strobe", conv_start, 1);
        check("R1 first slot voltage", slot_type, 0);
        cmp_on = 1;
        // R3/R6/R9: slow conversions, tick every cycle, code 3
        run(400);
        check("R6/R9 slow gap", gap, TS + 1);
        check("R3 code3 current run", last_run, 7);
        // R6: fast mode, code 0
        fast_mode = 1; idle_speed = 2'd0;
        run(300);
        check("R6/R9 fast gap", gap, TF + 1);
        check("R3 code0 current run", last_run, 0);
        // R4: balancing picks bal_speed
        bal_active = 1; bal_speed = 2'd1;
        run(300);
        check("R4 balancing code1 run", last_run, 1);
        bal_speed = 2'd2;
        run(300);
        check("R4 balancing code2 run", last_run, 3);
        bal_active = 0; idle_speed = 2'd1;
        run(300);
        check("R4 idle code1 run", last_run, 1);
        // R5: configuration changes at random times, sparse ticks
        tick_mode = 1;
        run(2000);
        tick_mode = 2; rnd_cfg = 1;
        run(20000);
        check("R5 model agreement under random changes", n_fail, 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule